// File: doc/BRIEF.md
# Buck Converter Fault Latch

This block watches the comparator flags of a synchronous buck controller and decides when the converter must stop switching. It runs on a fast system clock and receives a one-clock strobe that marks the start of each switching period. A current-limit hit at the start of a period makes the block skip high-side pulses for a run of periods and then watch a fixed window of periods. A second hit inside that window latches a fault. Over-voltage, under-voltage, a shorted feedback pin and a high-side switch fault also latch it, each after its own persistence time.

Once the fault is latched, the high-side pulse stays inhibited and the output discharge resistor is switched in. The low-side switch pulls the output down in bursts with hysteresis, so the output never swings negative. Only a reset or taking enable low clears the latch. While enable is low, all detection is held cleared and the discharge resistor stays on.

Top module: `buck_fault_guard`

## Requirements
- R1: After reset, faultLatched, hsInhibit and lsDischarge are 0. While enable is 0, the latch and all persistence counts are cleared, dischargeEn is 1, and any fault condition seen in that clock is ignored.
- R2: If curLimDet is 1 on a clock where cycStrobe is 1 and the over-current logic is idle, hsInhibit goes high on the next clock. It stays high until the clock after the 9th following strobe, so 9 switching periods are skipped in all.
- R3: Strobes 9 through 16 after the detecting strobe open a watch window. A curLimDet of 1 on any clock inside that window latches the fault on the next clock, but only if ssDone is 1.
- R4: If the window passes with no hit, the logic returns to idle at strobe 17 and a later fault is not latched. A curLimDet of 1 on strobe 17 itself starts a new skip run and is not counted as a window hit.
- R5: fbOver sampled as 1 on 16 strobes in a row latches the fault on the clock after the 16th, whatever ssDone is. A strobe that samples fbOver as 0 restarts the count.
- R6: fbUnder as 1 for UV_CLKS clocks in a row (default 200, 2 µs at 100 MHz) latches the fault if ssDone is 1 on the clock that completes the run. If the run completes with ssDone at 0, the fault is latched on the first clock in which ssDone is 1 while fbUnder is still 1.
- R7: While ssDone is 0, outAbove1V and fbBelow100m both at 1 for SHORT_CLKS clocks in a row (default 1400, 14 µs) latch the fault. With ssDone at 1, this condition never latches.
- R8: hsSampleStb and swAboveHalf both at 1 on one clock latch the fault on the next clock, during soft-start or after it.
- R9: While faultLatched is 1, hsInhibit and dischargeEn are both 1.
- R10: lsDischarge rises on the same clock as faultLatched. While the fault stays latched, lsDischarge falls on the clock after outBelowHalf is sampled at 1 while it is high. It rises again on the clock after outAbove0p8 is sampled at 1 while it is low. It is 0 whenever no fault is latched.
- R11: With enable at 1, a latched fault stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset (power cycle) |
| enable | input | 1 | Converter enable; low clears the latch |
| cycStrobe | input | 1 | One-clock pulse at the start of each switching period |
| curLimDet | input | 1 | Current-limit comparator |
| fbUnder | input | 1 | Feedback below the under-voltage threshold |
| fbOver | input | 1 | Feedback above 115 % of the reference |
| hsSampleStb | input | 1 | Low-side current-sampling instant |
| swAboveHalf | input | 1 | Switch node above 0.5 V |
| outAbove1V | input | 1 | Output above 1 V |
| outBelowHalf | input | 1 | Output below 0.5 V |
| outAbove0p8 | input | 1 | Output above 0.8 V |
| fbBelow100m | input | 1 | Feedback below 100 mV |
| ssDone | input | 1 | Soft-start complete |
| hsInhibit | output | 1 | Suppress the high-side pulse |
| faultLatched | output | 1 | Fault latch state |
| dischargeEn | output | 1 | Switch in the output discharge resistor |
| lsDischarge | output | 1 | Force the low-side switch on to discharge |

## Verification
Two functions can land on the same clock. One is the strobe that closes the over-current watch window, which may coincide with a fresh current-limit detect. The other is the latching of a fault, which may coincide with a discharge-threshold flag or with enable falling. The bench drives curLimDet exactly on strobe 17, raises a high-side trip in the clock where enable drops, and forces the latch while outBelowHalf is already high. A behavioural model that counts periods and clocks with plain integers judges every clock, and it expects a restart rather than a latch, enable to win over the trip, and the low-side drive to go high first.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

  typedef enum logic [1:0] {
    OC_IDLE  = 2'd0,
    OC_SKIP  = 2'd1,
    OC_WATCH = 2'd2
  } ocState_e;

  // Strobes from the control FSM into the counting datapath
  typedef struct packed {
    logic ocLoad;
    logic ocStep;
    logic clrAll;
  } dpCtrl_t;

  // Flags returned by the datapath
  typedef struct packed {
    logic ocSkipLast;
    logic ocWatchLast;
    logic ovTrip;
    logic uvTrip;
    logic shortTrip;
  } dpFlags_t;

endpackage

// File: rtl/fault_guard_run.sv
// Persistence counter: trip when 'hold' is seen on LIMIT consecutive
// advancing samples. Saturates so a later gate can still act.
module fault_guard_run #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic adv,
  input  logic hold,
  output logic trip
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (clr) begin
      runCnt <= '0;
    end else if (adv) begin
      if (!hold)              runCnt <= '0;
      else if (runCnt != TOP) runCnt <= runCnt + 1'b1;
    end
  end

  assign trip = !clr && adv && hold && (runCnt == TOP);
endmodule

// File: rtl/fault_guard_dp.sv
module fault_guard_dp
  import fault_guard_pkg::*;
#(
  parameter int OC_SKIP    = 8,
  parameter int OC_WATCH   = 8,
  parameter int OV_CYCLES  = 16,
  parameter int UV_CLKS    = 200,
  parameter int SHORT_CLKS = 1400
) (
  input  logic     clk,
  input  logic     rstN,
  input  dpCtrl_t  ctl,
  input  logic     cycStrobe,
  input  logic     fbOver,
  input  logic     fbUnder,
  input  logic     outAbove1V,
  input  logic     fbBelow100m,
  input  logic     ssDone,
  output dpFlags_t flags
);
  localparam int OC_LAST = OC_SKIP + OC_WATCH;
  localparam int OCW     = $clog2(OC_LAST + 1);

  logic [OCW-1:0] ocCyc;
  logic ovTrip, uvTrip, shortTrip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ocCyc <= '0;
    else if (ctl.clrAll)   ocCyc <= '0;
    else if (ctl.ocLoad)   ocCyc <= '0;
    else if (ctl.ocStep)   ocCyc <= ocCyc + 1'b1;
  end

  fault_guard_run #(.LIMIT(OV_CYCLES)) ovRun_i (
    .clk(clk), .rstN(rstN), .clr(ctl.clrAll),
    .adv(cycStrobe), .hold(fbOver), .trip(ovTrip));

  fault_guard_run #(.LIMIT(UV_CLKS)) uvRun_i (
    .clk(clk), .rstN(rstN), .clr(ctl.clrAll),
    .adv(1'b1), .hold(fbUnder), .trip(uvTrip));

  fault_guard_run #(.LIMIT(SHORT_CLKS)) shortRun_i (
    .clk(clk), .rstN(rstN), .clr(ctl.clrAll),
    .adv(1'b1), .hold(outAbove1V && fbBelow100m && !ssDone), .trip(shortTrip));

  always_comb begin
    flags.ocSkipLast  = (ocCyc == OCW'(OC_SKIP));
    flags.ocWatchLast = (ocCyc == OCW'(OC_LAST));
    flags.ovTrip      = ovTrip;
    flags.uvTrip      = uvTrip;
    flags.shortTrip   = shortTrip;
  end
endmodule

// File: rtl/fault_guard_ctrl.sv
module fault_guard_ctrl
  import fault_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     cycStrobe,
  input  logic     curLimDet,
  input  logic     ssDone,
  input  logic     hsSampleStb,
  input  logic     swAboveHalf,
  input  logic     outBelowHalf,
  input  logic     outAbove0p8,
  input  dpFlags_t flags,
  output dpCtrl_t  ctl,
  output logic     faultQ,
  output logic     hsInhibit,
  output logic     lsDischarge
);
  ocState_e ocState, ocNext;
  logic winHit, setAny, faultNext, lsNext, inhNext;

  always_comb begin
    ocNext     = ocState;
    ctl        = '0;
    ctl.clrAll = !enable;
    winHit     = 1'b0;
    case (ocState)
      OC_IDLE: begin
        if (cycStrobe && curLimDet) begin
          ocNext     = OC_SKIP;
          ctl.ocLoad = 1'b1;
        end
      end
      OC_SKIP: begin
        if (cycStrobe) begin
          ctl.ocStep = 1'b1;
          if (flags.ocSkipLast) ocNext = OC_WATCH;
        end
      end
      OC_WATCH: begin
        if (cycStrobe && flags.ocWatchLast) begin
          if (curLimDet) begin
            ocNext     = OC_SKIP;
            ctl.ocLoad = 1'b1;
          end else begin
            ocNext = OC_IDLE;
          end
        end else begin
          ctl.ocStep = cycStrobe;
          winHit     = curLimDet;
        end
      end
      default: ocNext = OC_IDLE;
    endcase
    if (!enable) ocNext = OC_IDLE;

    setAny = (hsSampleStb && swAboveHalf) || flags.ovTrip || flags.shortTrip ||
             (ssDone && (flags.uvTrip || winHit));
    faultNext = enable && (faultQ || setAny);

    if (!faultNext)       lsNext = 1'b0;
    else if (!faultQ)     lsNext = 1'b1;
    else if (lsDischarge) lsNext = !outBelowHalf;
    else                  lsNext = outAbove0p8;

    inhNext = faultNext || (ocNext == OC_SKIP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocState     <= OC_IDLE;
      faultQ      <= 1'b0;
      lsDischarge <= 1'b0;
      hsInhibit   <= 1'b0;
    end else begin
      ocState     <= ocNext;
      faultQ      <= faultNext;
      lsDischarge <= lsNext;
      hsInhibit   <= inhNext;
    end
  end
endmodule

// File: rtl/buck_fault_guard.sv
module buck_fault_guard
  import fault_guard_pkg::*;
#(
  parameter int OC_SKIP_CYCLES  = 8,
  parameter int OC_WATCH_CYCLES = 8,
  parameter int OV_CYCLES       = 16,
  parameter int UV_CLKS         = 200,
  parameter int SHORT_CLKS      = 1400
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic cycStrobe,
  input  logic curLimDet,
  input  logic fbUnder,
  input  logic fbOver,
  input  logic hsSampleStb,
  input  logic swAboveHalf,
  input  logic outAbove1V,
  input  logic outBelowHalf,
  input  logic outAbove0p8,
  input  logic fbBelow100m,
  input  logic ssDone,
  output logic hsInhibit,
  output logic faultLatched,
  output logic dischargeEn,
  output logic lsDischarge
);
  dpCtrl_t  ctl;
  dpFlags_t flags;
  logic     faultQ;

  fault_guard_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cycStrobe(cycStrobe),
    .curLimDet(curLimDet), .ssDone(ssDone), .hsSampleStb(hsSampleStb),
    .swAboveHalf(swAboveHalf), .outBelowHalf(outBelowHalf),
    .outAbove0p8(outAbove0p8), .flags(flags), .ctl(ctl), .faultQ(faultQ),
    .hsInhibit(hsInhibit), .lsDischarge(lsDischarge));

  fault_guard_dp #(
    .OC_SKIP(OC_SKIP_CYCLES), .OC_WATCH(OC_WATCH_CYCLES),
    .OV_CYCLES(OV_CYCLES), .UV_CLKS(UV_CLKS), .SHORT_CLKS(SHORT_CLKS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cycStrobe(cycStrobe),
    .fbOver(fbOver), .fbUnder(fbUnder), .outAbove1V(outAbove1V),
    .fbBelow100m(fbBelow100m), .ssDone(ssDone), .flags(flags));

  assign faultLatched = faultQ;
  assign dischargeEn  = faultQ || !enable;
endmodule

// File: rtl/buck_fault_guard_chk.sv
module buck_fault_guard_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic cycStrobe,
  input logic curLimDet,
  input logic hsSampleStb,
  input logic swAboveHalf,
  input logic outBelowHalf,
  input logic hsInhibit,
  input logic faultLatched,
  input logic dischargeEn,
  input logic lsDischarge
);
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !faultLatched); // R1

  AST_DISABLE_DISCHARGES: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> dischargeEn); // R1

  AST_SKIP_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hsInhibit) && !faultLatched) |-> $past(cycStrobe && curLimDet)); // R2

  AST_HS_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && hsSampleStb && swAboveHalf) |=> faultLatched); // R8

  AST_LATCH_INHIBITS: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (hsInhibit && dischargeEn)); // R9

  AST_LS_ONLY_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    lsDischarge |-> faultLatched); // R10

  AST_LS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && faultLatched && lsDischarge && outBelowHalf) |=> !lsDischarge); // R10

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (enable && faultLatched) |=> faultLatched); // R11
endmodule

bind buck_fault_guard buck_fault_guard_chk chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .cycStrobe(cycStrobe),
  .curLimDet(curLimDet), .hsSampleStb(hsSampleStb), .swAboveHalf(swAboveHalf),
  .outBelowHalf(outBelowHalf), .hsInhibit(hsInhibit),
  .faultLatched(faultLatched), .dischargeEn(dischargeEn),
  .lsDischarge(lsDischarge));

// File: tb/buck_fault_guard_tb_top.sv
module buck_fault_guard_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SKIP_N  = 8;
  localparam int WATCH_N = 8;
  localparam int OV_N    = 16;
  localparam int UV_N    = 200;
  localparam int SH_N    = 1400;
  localparam int STB_PER = 10;

  logic clk = 0, rstN = 0, enable = 0, cycStrobe = 0;
  logic curLimDet = 0, fbUnder = 0, fbOver = 0, hsSampleStb = 0, swAboveHalf = 0;
  logic outAbove1V = 0, outBelowHalf = 0, outAbove0p8 = 0, fbBelow100m = 0, ssDone = 0;
  logic hsInhibit, faultLatched, dischargeEn, lsDischarge;

  int checks = 0, errors = 0, phase = 0;
  bit checking = 0, done = 0;

  // reference model state
  int mMode = 0, mCyc = 0, mOv = 0, mUv = 0, mSh = 0;
  bit mLat = 0, mLs = 0, mInh = 0;

  buck_fault_guard dut_i (.*);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (phase == STB_PER - 1) begin phase = 0; cycStrobe = 1; end
    else begin phase = phase + 1; cycStrobe = 0; end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit hsT, ovT, uvT, shT, winT, newLat, hold;
    int nMode, nCyc;
    if (!rstN || !enable) begin
      mMode = 0; mCyc = 0; mOv = 0; mUv = 0; mSh = 0;
      mLat = 0; mLs = 0; mInh = 0;
      return;
    end
    hsT = hsSampleStb && swAboveHalf;
    ovT = 0;
    if (cycStrobe) begin
      if (fbOver) begin
        ovT = (mOv >= OV_N - 1);
        if (mOv < OV_N - 1) mOv++;
      end else mOv = 0;
    end
    uvT = fbUnder && ssDone && (mUv >= UV_N - 1);
    if (!fbUnder) mUv = 0; else if (mUv < UV_N - 1) mUv++;
    hold = !ssDone && outAbove1V && fbBelow100m;
    shT = hold && (mSh >= SH_N - 1);
    if (!hold) mSh = 0; else if (mSh < SH_N - 1) mSh++;
    winT = 0; nMode = mMode; nCyc = mCyc;
    if (mMode == 0) begin
      if (cycStrobe && curLimDet) begin nMode = 1; nCyc = 0; end
    end else if (mMode == 1) begin
      if (cycStrobe) begin
        nCyc = mCyc + 1;
        if (nCyc == SKIP_N + 1) nMode = 2;
      end
    end else begin
      if (cycStrobe && (mCyc + 1 == SKIP_N + WATCH_N + 1)) begin
        if (curLimDet) begin nMode = 1; nCyc = 0; end else nMode = 0;
      end else begin
        if (cycStrobe) nCyc = mCyc + 1;
        winT = curLimDet && ssDone;
      end
    end
    newLat = mLat || hsT || ovT || uvT || shT || winT;
    if (!newLat) mLs = 0;
    else if (!mLat) mLs = 1;
    else if (mLs && outBelowHalf) mLs = 0;
    else if (!mLs && outAbove0p8) mLs = 1;
    mLat = newLat; mMode = nMode; mCyc = nCyc;
    mInh = newLat || (nMode == 1);
  endtask

  always @(posedge clk) begin
    modelStep();
    #3;
    if (checking && !done) begin
      chk("R2 model hsInhibit", hsInhibit, mInh);
      chk("R11 model faultLatched", faultLatched, mLat);
      chk("R9 model dischargeEn", dischargeEn, mLat || !enable);
      chk("R10 model lsDischarge", lsDischarge, mLs);
    end
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic waitStrobe(); do step(); while (!cycStrobe); endtask
  task automatic clearLatch(); enable = 0; step(); enable = 1; step(); endtask
  task automatic limitAtStrobe(); waitStrobe(); curLimDet = 1; step(); curLimDet = 0; endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checking = 1;
    repeat (3) step();
    chk("R1 reset latch", faultLatched, 0);
    chk("R1 reset inhibit", hsInhibit, 0);
    chk("R1 reset lowside", lsDischarge, 0);
    chk("R1 discharge while disabled", dischargeEn, 1);
    rstN = 1; step();
    enable = 1; step();
    chk("R1 discharge off when enabled", dischargeEn, 0);

    // R2 / R4: skip run then recovery
    ssDone = 1;
    limitAtStrobe();
    chk("R2 inhibit after limit", hsInhibit, 1);
    repeat (8) waitStrobe();
    step();
    chk("R2 inhibit through strobe 8", hsInhibit, 1);
    waitStrobe(); step();
    chk("R2 inhibit released after strobe 9", hsInhibit, 0);
    repeat (8) waitStrobe();
    step();
    chk("R4 no latch after quiet window", faultLatched, 0);

    // R3 / R9 / R10: hit inside window latches
    limitAtStrobe();
    repeat (10) waitStrobe();
    step();
    curLimDet = 1; step(); curLimDet = 0;
    chk("R3 window hit latches", faultLatched, 1);
    chk("R9 inhibit while latched", hsInhibit, 1);
    chk("R9 discharge while latched", dischargeEn, 1);
    chk("R10 lowside on at latch", lsDischarge, 1);
    outBelowHalf = 1; step(); outBelowHalf = 0;
    chk("R10 lowside off below 0.5V", lsDischarge, 0);
    repeat (3) step();
    chk("R10 lowside stays off", lsDischarge, 0);
    outAbove0p8 = 1; step(); outAbove0p8 = 0;
    chk("R10 lowside on above 0.8V", lsDischarge, 1);
    repeat (20) step();
    chk("R11 latch held", faultLatched, 1);
    enable = 0; step();
    chk("R1 disable clears latch", faultLatched, 0);
    chk("R1 disable discharge", dischargeEn, 1);
    enable = 1; step();
    chk("R11 stays clear after toggle", faultLatched, 0);

    // R3: window hit during soft-start is ignored
    ssDone = 0;
    limitAtStrobe();
    repeat (10) waitStrobe();
    step();
    curLimDet = 1; step(); curLimDet = 0;
    chk("R3 window hit blocked in soft-start", faultLatched, 0);
    repeat (8) waitStrobe();
    step();

    // R4: new detect exactly on strobe 17 restarts skipping
    ssDone = 1;
    limitAtStrobe();
    repeat (16) waitStrobe();
    step();
    limitAtStrobe();
    chk("R4 restart on closing strobe", hsInhibit, 1);
    chk("R4 closing strobe not a hit", faultLatched, 0);
    repeat (18) waitStrobe();
    step();

    // R5: over-voltage persistence, during soft-start
    ssDone = 0;
    waitStrobe(); step();
    fbOver = 1;
    repeat (15) waitStrobe();
    step(); fbOver = 0;
    waitStrobe(); step();
    chk("R5 fifteen strobes no latch", faultLatched, 0);
    fbOver = 1;
    repeat (16) waitStrobe();
    step();
    chk("R5 sixteen strobes latch", faultLatched, 1);
    fbOver = 0; clearLatch();

    // R6: under-voltage timing and soft-start gate
    ssDone = 1;
    fbUnder = 1; repeat (UV_N - 1) step(); fbUnder = 0;
    chk("R6 one clock short no latch", faultLatched, 0);
    step();
    fbUnder = 1; repeat (UV_N) step();
    chk("R6 full time latches", faultLatched, 1);
    fbUnder = 0; clearLatch();
    ssDone = 0;
    fbUnder = 1; repeat (UV_N + 100) step();
    chk("R6 blocked in soft-start", faultLatched, 0);
    ssDone = 1; step();
    chk("R6 latches when soft-start ends", faultLatched, 1);
    fbUnder = 0; clearLatch();

    // R7: feedback short during soft-start
    outAbove1V = 1; fbBelow100m = 1;
    repeat (SH_N + 100) step();
    chk("R7 ignored after soft-start", faultLatched, 0);
    ssDone = 0;
    repeat (SH_N - 1) step();
    outAbove1V = 0; step();
    chk("R7 one clock short no latch", faultLatched, 0);
    outAbove1V = 1;
    repeat (SH_N) step();
    chk("R7 full time latches", faultLatched, 1);
    outAbove1V = 0; fbBelow100m = 0; clearLatch();

    // R8: high-side fault any time
    hsSampleStb = 1; step(); hsSampleStb = 0;
    chk("R8 no trip without switch high", faultLatched, 0);
    swAboveHalf = 1; step();
    hsSampleStb = 1; outBelowHalf = 1; step(); hsSampleStb = 0;
    chk("R8 trip in soft-start", faultLatched, 1);
    chk("R10 lowside high on latching clock", lsDischarge, 1);
    step(); outBelowHalf = 0;
    clearLatch();
    hsSampleStb = 1; enable = 0; step(); hsSampleStb = 0;
    chk("R1 trip ignored while disabled", faultLatched, 0);
    enable = 1; swAboveHalf = 0; step();
    chk("R1 still clear after enable", faultLatched, 0);

    repeat (5) step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule